// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This unit watches a set of general-purpose pins, grouped into banks of 32, and records level transitions as sticky status bits. Every pin has its own rising-edge enable, falling-edge enable and direction bit. Only pins configured as inputs can record an event, and only pins whose index is below the configured line count. Software clears recorded events by writing ones to a bank's status through a clear strobe. The strobe carries a bank number and a bit mask.

The status is reduced to three registered interrupt lines. Pin 0 and pin 1 each have a dedicated line. All other pins share a third, OR-combined line. The unit also raises a one-cycle wake request when the CPU is halted and a wake-capable input pin changes level. The set of wake-capable pins is a fixed mask per bank.

The pin levels must already be synchronised to the clock. Edges are found by comparing each level with a registered copy of the previous cycle's level. In the first cycle after reset there is no previous level yet, so that cycle only loads the copy and records no event. Register-bus decoding is left to the surrounding logic.

Top module: `gpio_edge_irq`

## Requirements
- R1: A pin whose level goes from 0 to 1 sets its status bit on the next clock edge when its rising enable is 1 and its direction bit is 0 (input).
- R2: A pin whose level goes from 1 to 0 sets its status bit on the next clock edge when its falling enable is 1 and its direction bit is 0.
- R3: A pin whose direction bit is 1 (output) never sets its status bit and never causes a wake request.
- R4: Status bits are sticky. While `clr_valid` is 1, each 1 in `clr_mask` clears bit n of bank `clr_bank` (status index `clr_bank*32+n`). Each 0 in `clr_mask` leaves the bit unchanged. A clear takes effect on the same edge as the strobe.
- R5: When an edge event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R6: `irq_pin0` equals status bit 0 of bank 0, and `irq_pin1` equals status bit 1 of bank 0, in the same cycle the status changes.
- R7: `irq_other` is the OR of status bits 31 to 2 of bank 0 and of every bit of the higher banks, in the same cycle the status changes.
- R8: `wake_req` is 1 for one cycle after an edge in which `cpu_halted` was 1 and some input pin changed level. The pin must be set in the wake mask of its bank: 0x8003FE1B for bank 0, 0x002001FC for bank 1, 0xEC080000 for bank 2 and 0x0012007F for bank 3. The edge enables play no part in this.
- R9: Pins with index at or above `NUM_LINES` never set a status bit and never cause a wake request.
- R10: Reset clears all status bits and outputs. The first clock after reset only loads the previous-level copy, so a pin that is already high at that point records no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_level | input | NUM_BANKS*32 | Synchronised pin levels, index = bank*32+bit |
| pin_dir | input | NUM_BANKS*32 | Direction per pin, 1 = output |
| rise_en | input | NUM_BANKS*32 | Rising-edge enable per pin |
| fall_en | input | NUM_BANKS*32 | Falling-edge enable per pin |
| clr_valid | input | 1 | Write-one-to-clear strobe |
| clr_bank | input | BANK_SEL_W | Bank addressed by the clear |
| clr_mask | input | 32 | Bits to clear in that bank |
| cpu_halted | input | 1 | CPU halted flag gating wake requests |
| edge_status | output | NUM_BANKS*32 | Sticky event status, all banks |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_other | output | 1 | Shared interrupt for all other pins |
| wake_req | output | 1 | One-cycle wake request |

## Verification
The bench releases reset with every pin high and all enables on. A design that detects edges against a zeroed history would record a burst of false rising events there. It clears a bit in the same cycle that a new edge arrives on it, which catches a clear-priority design losing the event. It also checks that a zero in the clear mask preserves the bit, which a design that overwrites the bank would fail. Wake requests are probed with enables off, with a pin outside the wake mask, with an output pin, with a pin above the line count and while the CPU is running. Each probe would expose a wake path gated by the wrong term, and a stretched request would show up as a second cycle of `wake_req`.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int unsigned MASK_W = 32;

  // fixed set of pins able to wake a halted CPU, per bank
  function automatic logic [MASK_W-1:0] wake_capable(input int unsigned bank);
    logic [MASK_W-1:0] m;
    case (bank)
      0: m = 32'h8003_FE1B;
      1: m = 32'h0020_01FC;
      2: m = 32'hEC08_0000;
      3: m = 32'h0012_007F;
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_pkg::*;
#(
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned BANK_IDX  = 0,
  parameter int unsigned NUM_LINES = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              armed,
  input  logic [BANK_W-1:0] level,
  input  logic [BANK_W-1:0] dir,
  input  logic [BANK_W-1:0] rise_en,
  input  logic [BANK_W-1:0] fall_en,
  input  logic              clr_hit,
  input  logic [BANK_W-1:0] clr_mask,
  output logic [BANK_W-1:0] status_q,
  output logic [BANK_W-1:0] status_nxt,
  output logic              wake_hit
);

  function automatic logic [BANK_W-1:0] present_lines();
    logic [BANK_W-1:0] m;
    for (int b = 0; b < int'(BANK_W); b++)
      m[b] = ((BANK_IDX * BANK_W + b) < NUM_LINES);
    return m;
  endfunction

  localparam logic [BANK_W-1:0] LINE_MASK = present_lines();
  localparam logic [BANK_W-1:0] WAKE_MASK = BANK_W'(wake_capable(BANK_IDX));

  logic [BANK_W-1:0] prev_q;
  logic [BANK_W-1:0] qual;
  logic [BANK_W-1:0] rise_ev;
  logic [BANK_W-1:0] fall_ev;
  logic [BANK_W-1:0] clr_vec;

  always_comb begin
    qual       = ~dir & LINE_MASK & {BANK_W{armed}};
    rise_ev    = level & ~prev_q & rise_en & qual;
    fall_ev    = ~level & prev_q & fall_en & qual;
    clr_vec    = clr_hit ? clr_mask : '0;
    status_nxt = (status_q & ~clr_vec) | rise_ev | fall_ev;
    wake_hit   = |((level ^ prev_q) & qual & WAKE_MASK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= level;
      status_q <= status_nxt;
    end
  end

  // R4: a set bit only drops where the clear mask asked for it
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(status_q) & ~$past(clr_vec) & ~status_q) == '0));

  // R3 / R9: newly set bits come from present input pins that changed level
  a_r3_new_bit_qualified: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & ~$past(status_q) &
               ~($past(level ^ prev_q) & ~$past(dir) & LINE_MASK)) == '0));

  // R5: an event in a cycle leaves its bit set even under a clear
  a_r5_edge_beats_clear: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(rise_ev | fall_ev) & ~status_q) == '0));

endmodule

// File: rtl/gpio_irq_reduce.sv
module gpio_irq_reduce #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_BANKS*BANK_W-1:0]   status_nxt,
  output logic                          irq_pin0,
  output logic                          irq_pin1,
  output logic                          irq_other
);

  localparam int unsigned TOTAL = NUM_BANKS * BANK_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pin0  <= 1'b0;
      irq_pin1  <= 1'b0;
      irq_other <= 1'b0;
    end else begin
      irq_pin0  <= status_nxt[0];
      irq_pin1  <= status_nxt[1];
      irq_other <= |status_nxt[TOTAL-1:2];
    end
  end

endmodule

// File: rtl/gpio_wake_pulse.sv
module gpio_wake_pulse #(
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_BANKS-1:0] bank_hit,
  input  logic                 cpu_halted,
  output logic                 wake_req
);

  always_ff @(posedge clk) begin
    if (rst) wake_req <= 1'b0;
    else     wake_req <= cpu_halted & (|bank_hit);
  end

  // R8: a request only follows a cycle in which the CPU was halted
  a_r8_needs_halt: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> $past(cpu_halted));

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int unsigned NUM_BANKS  = 4,
  parameter int unsigned BANK_W     = 32,
  parameter int unsigned NUM_LINES  = 128,
  parameter int unsigned BANK_SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_BANKS*BANK_W-1:0]   pin_level,
  input  logic [NUM_BANKS*BANK_W-1:0]   pin_dir,
  input  logic [NUM_BANKS*BANK_W-1:0]   rise_en,
  input  logic [NUM_BANKS*BANK_W-1:0]   fall_en,
  input  logic                          clr_valid,
  input  logic [BANK_SEL_W-1:0]         clr_bank,
  input  logic [BANK_W-1:0]             clr_mask,
  input  logic                          cpu_halted,
  output logic [NUM_BANKS*BANK_W-1:0]   edge_status,
  output logic                          irq_pin0,
  output logic                          irq_pin1,
  output logic                          irq_other
  ,
  output logic                          wake_req
);

  localparam int unsigned TOTAL = NUM_BANKS * BANK_W;

  logic                 armed_q;
  logic [TOTAL-1:0]     status_nxt;
  logic [NUM_BANKS-1:0] bank_hit;

  // history is valid from the second clock after reset
  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= 1'b1;
  end

  for (genvar k = 0; k < int'(NUM_BANKS); k++) begin : g_bank
    logic clr_hit;
    assign clr_hit = clr_valid && (clr_bank == BANK_SEL_W'(k));

    gpio_edge_bank #(
      .BANK_W   (BANK_W),
      .BANK_IDX (k),
      .NUM_LINES(NUM_LINES)
    ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .armed     (armed_q),
      .level     (pin_level[k*BANK_W +: BANK_W]),
      .dir       (pin_dir[k*BANK_W +: BANK_W]),
      .rise_en   (rise_en[k*BANK_W +: BANK_W]),
      .fall_en   (fall_en[k*BANK_W +: BANK_W]),
      .clr_hit   (clr_hit),
      .clr_mask  (clr_mask),
      .status_q  (edge_status[k*BANK_W +: BANK_W]),
      .status_nxt(status_nxt[k*BANK_W +: BANK_W]),
      .wake_hit  (bank_hit[k])
    );
  end

  gpio_irq_reduce #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W)
  ) u_irq (
    .clk       (clk),
    .rst       (rst),
    .status_nxt(status_nxt),
    .irq_pin0  (irq_pin0),
    .irq_pin1  (irq_pin1),
    .irq_other (irq_other)
  );

  gpio_wake_pulse #(
    .NUM_BANKS(NUM_BANKS)
  ) u_wake (
    .clk       (clk),
    .rst       (rst),
    .bank_hit  (bank_hit),
    .cpu_halted(cpu_halted),
    .wake_req  (wake_req)
  );

  // R6: dedicated lines track bank 0 bits 0 and 1
  a_r6_pin0_line: assert property (@(posedge clk) disable iff (rst)
    irq_pin0 == edge_status[0]);
  a_r6_pin1_line: assert property (@(posedge clk) disable iff (rst)
    irq_pin1 == edge_status[1]);

  // R7: shared line tracks every other status bit
  a_r7_shared_line: assert property (@(posedge clk) disable iff (rst)
    irq_other == (|edge_status[TOTAL-1:2]));

  // R10: nothing is recorded before the history copy is loaded
  a_r10_no_event_unarmed: assert property (@(posedge clk) disable iff (rst)
    !armed_q |=> (edge_status == '0));

endmodule

// File: tb/gpio_edge_irq_test.sv
module gpio_edge_irq_test;

  localparam int TOT   = 128;
  localparam int LINES = 100;

  logic             clk = 1'b0;
  logic             rst;
  logic [TOT-1:0]   pin_level, pin_dir, rise_en, fall_en;
  logic             clr_valid;
  logic [1:0]       clr_bank;
  logic [31:0]      clr_mask;
  logic             cpu_halted;
  logic [TOT-1:0]   edge_status;
  logic             irq_pin0, irq_pin1, irq_other, wake_req;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  gpio_edge_irq #(.NUM_BANKS(4), .BANK_W(32), .NUM_LINES(LINES)) uut (
    .clk(clk), .rst(rst), .pin_level(pin_level), .pin_dir(pin_dir),
    .rise_en(rise_en), .fall_en(fall_en), .clr_valid(clr_valid),
    .clr_bank(clr_bank), .clr_mask(clr_mask), .cpu_halted(cpu_halted),
    .edge_status(edge_status), .irq_pin0(irq_pin0), .irq_pin1(irq_pin1),
    .irq_other(irq_other), .wake_req(wake_req)
  );

  // ---------------- behavioural reference ----------------
  logic [TOT-1:0] m_status, m_prev;
  bit m_armed, m_irq0, m_irq1, m_irqx, m_wake;

  function automatic bit wake_pin(input int i);
    logic [31:0] w [4];
    w[0] = 32'h8003FE1B; w[1] = 32'h002001FC;
    w[2] = 32'hEC080000; w[3] = 32'h0012007F;
    return w[i / 32][i % 32];
  endfunction

  always @(posedge clk) begin
    logic [TOT-1:0] nxt;
    bit wk;
    if (rst) begin
      m_status = '0; m_prev = '0; m_armed = 0;
      m_irq0 = 0; m_irq1 = 0; m_irqx = 0; m_wake = 0;
    end else begin
      nxt = m_status;
      wk  = 0;
      if (clr_valid)
        for (int b = 0; b < 32; b++)
          if (clr_mask[b]) nxt[clr_bank * 32 + b] = 1'b0;
      for (int i = 0; i < TOT; i++) begin
        if (m_armed && i < LINES && !pin_dir[i]) begin
          if (pin_level[i] && !m_prev[i] && rise_en[i]) nxt[i] = 1'b1;
          if (!pin_level[i] && m_prev[i] && fall_en[i]) nxt[i] = 1'b1;
          if (pin_level[i] != m_prev[i] && wake_pin(i)) wk = 1;
        end
      end
      m_wake   = wk && cpu_halted;
      m_status = nxt;
      m_irq0   = nxt[0];
      m_irq1   = nxt[1];
      m_irqx   = |nxt[TOT-1:2];
      m_prev   = pin_level;
      m_armed  = 1;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [TOT-1:0] act, input logic [TOT-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk("R4 status vs model", edge_status, m_status);
    chk("R6 irq_pin0 vs model", TOT'(irq_pin0), TOT'(m_irq0));
    chk("R6 irq_pin1 vs model", TOT'(irq_pin1), TOT'(m_irq1));
    chk("R7 irq_other vs model", TOT'(irq_other), TOT'(m_irqx));
    chk("R8 wake_req vs model", TOT'(wake_req), TOT'(m_wake));
  endtask

  task automatic clear(input int bank, input logic [31:0] mask);
    clr_valid = 1; clr_bank = 2'(bank); clr_mask = mask;
    step();
    clr_valid = 0; clr_mask = '0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; pin_level = '1; pin_dir = '0; rise_en = '1; fall_en = '1;
    clr_valid = 0; clr_bank = 0; clr_mask = '0; cpu_halted = 0;
    repeat (3) step();
    chk("R10 reset status", edge_status, '0);
    chk("R10 reset irqs", TOT'({irq_pin0, irq_pin1, irq_other, wake_req}), '0);

    // pins already high at reset release: no rising event
    rst = 0;
    step(); step();
    chk("R10 no event on first cycle", edge_status, '0);

    // all pins fall
    pin_level = '0;
    step();
    chk("R2 falling edges recorded", edge_status[LINES-1:0], {LINES{1'b1}});
    chk("R9 lines above count ignored", TOT'(edge_status[TOT-1:LINES]), '0);
    chk("R6 pin0 line", TOT'(irq_pin0), 1);
    chk("R7 shared line", TOT'(irq_other), 1);

    // write-one-to-clear
    clear(1, 32'h0000FFFF);
    chk("R4 partial clear", TOT'(edge_status[63:32]), TOT'(32'hFFFF0000));
    clear(0, 32'h0);
    chk("R4 zero mask keeps bits", TOT'(edge_status[31:0]), TOT'(32'hFFFFFFFF));
    for (int b = 0; b < 4; b++) clear(b, '1);
    chk("R4 full clear", edge_status, '0);

    // outputs ignored
    pin_dir = {96'b0, 32'hFFFFFFFF};
    pin_level[3] = 1;
    step();
    chk("R3 output pin no event", edge_status, '0);
    pin_dir = '0;
    step();
    chk("R3 direction change alone no event", edge_status, '0);

    // rising enable only on pin 0
    rise_en = 128'h1; fall_en = '0;
    pin_level[0] = 1; pin_level[1] = 1;
    step();
    chk("R1 rising on enabled pin", edge_status, 128'h1);
    chk("R1 irq_pin1 stays low", TOT'(irq_pin1), 0);

    // edge beats clear
    rise_en = 128'h3;
    pin_level[1] = 0;
    step();
    pin_level[1] = 1;
    clear(0, 32'h3);
    chk("R5 edge wins over clear", TOT'(edge_status[1:0]), 2'b10);
    chk("R6 irq_pin1 follows", TOT'(irq_pin1), 1);

    clear(0, '1);
    rise_en = '1;
    pin_level[70] = 1;
    step();
    chk("R7 shared line from bank 2", TOT'({irq_other, irq_pin0}), 2'b10);
    clear(2, '1);
    chk("R7 shared line drops", TOT'(irq_other), 0);

    // wake requests
    rise_en = '0; fall_en = '0; cpu_halted = 1;
    pin_level[0] = 0;
    step();
    chk("R8 wake on masked pin", TOT'(wake_req), 1);
    step();
    chk("R8 single-cycle pulse", TOT'(wake_req), 0);
    pin_level[2] = ~pin_level[2];
    step();
    chk("R8 pin outside wake mask", TOT'(wake_req), 0);
    cpu_halted = 0; pin_level[0] = 1;
    step();
    chk("R8 no wake while running", TOT'(wake_req), 0);
    cpu_halted = 1; pin_level[116] = ~pin_level[116];
    step();
    chk("R9 absent line no wake", TOT'(wake_req), 0);
    pin_dir[0] = 1; pin_level[0] = 0;
    step();
    chk("R3 output pin no wake", TOT'(wake_req), 0);
    pin_dir = '0; pin_level[96] = ~pin_level[96];
    step();
    chk("R8 wake from bank 3", TOT'(wake_req), 1);
    chk("R8 enables off leave status", edge_status, '0);

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      logic [TOT-1:0] flip;
      flip = {$urandom & $urandom, $urandom & $urandom,
              $urandom & $urandom, $urandom & $urandom};
      pin_level = pin_level ^ flip;
      if ((n % 50) == 0) begin
        pin_dir = {$urandom & $urandom, $urandom & $urandom,
                   $urandom & $urandom, $urandom & $urandom};
        rise_en = {$urandom, $urandom, $urandom, $urandom};
        fall_en = {$urandom, $urandom, $urandom, $urandom};
      end
      cpu_halted = $urandom_range(0, 1) == 1;
      clr_valid  = $urandom_range(0, 3) == 0;
      clr_bank   = 2'($urandom_range(0, 3));
      clr_mask   = $urandom;
      step();
    end
    clr_valid = 0;

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule